// File: doc/BRIEF.md
# Serial Control Register Port

This block takes 16-bit control words from a three-wire serial port and turns them into the static control fields of a dual-PLL audio clock generator. The three wires are a bit clock, a data line and a strobe. Data is shifted in most-significant bit first, one bit on each rising edge of the bit clock, while the strobe is low. A rising strobe then commits the word. The top six bits of the word act as an address prefix. The prefix selects the mode register, the configuration register, or neither.

The mode register holds:
- six clock-output enables;
- a two-bit sampling-rate code;
- a two-bit sampling-frequency-group code.

The configuration register holds one bit that selects the alternate frequency pair for the second system clock. When all six enables are cleared, a power-down flag rises. The serial port keeps running, so a later write can restore operation.

The three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser, and the bit-clock and strobe edges are detected in the system clock domain. The system clock must therefore run at least four times faster than the bit clock.

Top module: `sercfg_regif`

## Requirements
- R1: After synchronous reset, the outputs read as follows: out_en_o = 6'b111111, rate_sel_o = 2'b00 (standard rate), grp_sel_o = 2'b00 (48 kHz group), alt_cfg_o = 0 and pwrdn_o = 0.
- R2: A word is committed on a rising strobe only if at least 16 bit-clock rising edges have occurred since the previous rising strobe (or since reset). A rising strobe after fewer bits changes no output.
- R3: A committed word whose bits 15..10 equal 6'b011100 is a mode write, with these fields:
  - out_en_o[i] takes word bit 4+i, for i = 0..5;
  - rate_sel_o takes bits 3..2;
  - grp_sel_o takes bits 1..0.
- R4: A committed word whose bits 15..10 equal 6'b011011 is a configuration write. alt_cfg_o takes word bit 4, and every other low bit of that word has no effect on any output.
- R5: Group codes 00 (48 kHz), 01 (44.1 kHz) and 10 (32 kHz) are stored. A mode write that carries group code 11 leaves grp_sel_o at its previous value and still updates the other mode fields.
- R6: Rate codes 00 (standard), 01 (double) and 10 (half) are stored. A mode write that carries rate code 11 leaves rate_sel_o at its previous value and still updates the other mode fields.
- R7: A committed word with any other prefix changes no output.
- R8: pwrdn_o is 1 exactly when all six enables are 0. Words are still accepted in that state, and a mode write with any enable set clears pwrdn_o.
- R9: When more than 16 bits are shifted in before the strobe rises, the last 16 bits received form the word.
- R10: Suppose the strobe pin rises between two system-clock edges. The outputs keep their old values through the third following rising edge and show the new values after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit-clock rate |
| rst_n | input | 1 | Synchronous active-low reset, loads the defaults |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data, MSB first, sampled on the rising bit-clock edge |
| ser_stb_i | input | 1 | Strobe; held low while shifting, its rising edge commits the word |
| out_en_o | output | 6 | Clock-output enables |
| rate_sel_o | output | 2 | Sampling-rate code |
| grp_sel_o | output | 2 | Sampling-frequency-group code |
| alt_cfg_o | output | 1 | Alternate frequency pair for the second system clock |
| pwrdn_o | output | 1 | Power-down flag, high when every enable is 0 |

## Verification
The strobe's rising edge becomes visible on the outputs after four system-clock edges:
- two synchroniser flops;
- the edge-detect and word-capture register;
- the register-file update.

The bench drives every pin on the falling system-clock edge and holds the bit clock for four system clocks per phase. After each strobe pulse it waits well past the fourth edge before it compares the outputs. One directed test samples half a cycle after the third edge, expecting the old values, and again after the fourth, expecting the new ones, to pin that latency down exactly. Words that must be ignored are checked by reading all outputs after their strobe and before the next word is sent.

// File: rtl/sercfg_pkg.sv
// Package: shared widths, address prefixes and field codes for the
// serial control register port. Assumes a 16-bit word with a 6-bit prefix.
package sercfg_pkg;
    localparam int WORD_BITS   = 16;
    localparam int PREFIX_BITS = 6;
    localparam int EN_BITS     = 6;
    localparam int CODE_BITS   = 2;

    localparam logic [PREFIX_BITS-1:0] PFX_MODE = 6'b011100;
    localparam logic [PREFIX_BITS-1:0] PFX_CFG  = 6'b011011;

    // Bit positions inside a word that the decoder relies on.
    localparam int EN_LSB   = 4;
    localparam int RATE_LSB = 2;
    localparam int GRP_LSB  = 0;
    localparam int ALT_BIT  = 4;

    typedef enum logic [CODE_BITS-1:0] {
        RATE_STD  = 2'b00,
        RATE_DBL  = 2'b01,
        RATE_HALF = 2'b10,
        RATE_RSVD = 2'b11
    } rate_e;

    typedef enum logic [CODE_BITS-1:0] {
        GRP_48K  = 2'b00,
        GRP_44K1 = 2'b01,
        GRP_32K  = 2'b10,
        GRP_RSVD = 2'b11
    } grp_e;

    typedef struct packed {
        logic [EN_BITS-1:0] en;
        rate_e              rate;
        grp_e               grp;
        logic               alt;
    } ctl_t;

    localparam ctl_t CTL_DEFAULT = '{en: {EN_BITS{1'b1}}, rate: RATE_STD, grp: GRP_48K, alt: 1'b0};
endpackage

// File: rtl/sercfg_sync.sv
// Module: multi-bit synchroniser. Each bit passes through STAGES flops in
// series. Assumes every bit is an independent slow level; no bus coherency.
module sercfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sercfg_shifter.sv
// Module: edge detection and word assembly. Shifts in one data bit per
// rising bit clock and counts bits up to WORD_BITS. On a rising strobe,
// emits a one-cycle word_vld if a full word was received, then clears the
// count. Assumes synchronised inputs, with data stable at the bit-clock rise.
module sercfg_shifter #(
    parameter int WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk_s,
    input  logic                 bdat_s,
    input  logic                 stb_s,
    output logic                 word_vld,
    output logic [WORD_BITS-1:0] word
);
    localparam int CNT_W = $clog2(WORD_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);

    logic                 bclk_prev_q, stb_prev_q;
    logic                 bclk_rise, stb_rise;
    logic [WORD_BITS-1:0] shift_q;
    logic [CNT_W-1:0]     cnt_q;

    // Remember the last synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_prev_q <= 1'b0;
            stb_prev_q  <= 1'b0;
        end else begin
            bclk_prev_q <= bclk_s;
            stb_prev_q  <= stb_s;
        end
    end

    assign bclk_rise = bclk_s & ~bclk_prev_q;
    assign stb_rise  = stb_s & ~stb_prev_q;

    // Shift the data, count the bits, and capture the word on a full strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= '0;
            cnt_q    <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (bclk_rise) begin
                shift_q <= {shift_q[WORD_BITS-2:0], bdat_s};
                if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
            end
            if (stb_rise) begin
                cnt_q <= '0;
                if (cnt_q == CNT_FULL) begin
                    word_vld <= 1'b1;
                    word     <= shift_q;
                end
            end
        end
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);
    p_short_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && cnt_q != CNT_FULL) |=> !word_vld);
    p_stb_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise |=> (cnt_q <= 1));
endmodule

// File: rtl/sercfg_regs.sv
// Module: prefix decode and the two control registers. Applies mode and
// configuration writes, keeps the old value for reserved rate or group
// codes, and drops unknown prefixes. Assumes wr_vld is a single-cycle pulse.
module sercfg_regs
    import sercfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_vld,
    input  logic [WORD_BITS-1:0] wr_word,
    output ctl_t                 ctl,
    output logic                 pwrdn
);
    logic [PREFIX_BITS-1:0] prefix;
    logic                   is_mode, is_cfg;
    rate_e                  new_rate;
    grp_e                   new_grp;

    assign prefix   = wr_word[WORD_BITS-1 -: PREFIX_BITS];
    assign is_mode  = wr_vld && (prefix == PFX_MODE);
    assign is_cfg   = wr_vld && (prefix == PFX_CFG);
    assign new_rate = rate_e'(wr_word[RATE_LSB +: CODE_BITS]);
    assign new_grp  = grp_e'(wr_word[GRP_LSB +: CODE_BITS]);

    // Update the control fields selected by the decoded prefix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= CTL_DEFAULT;
        end else begin
            if (is_mode) begin
                ctl.en <= wr_word[EN_LSB +: EN_BITS];
                if (new_rate != RATE_RSVD) ctl.rate <= new_rate;
                if (new_grp != GRP_RSVD)   ctl.grp  <= new_grp;
            end
            if (is_cfg) ctl.alt <= wr_word[ALT_BIT];
        end
    end

    assign pwrdn = ~|ctl.en;

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_mode && !is_cfg) |=> $stable(ctl));
    p_rate_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mode && new_rate == RATE_RSVD) |=> $stable(ctl.rate));
    p_grp_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mode && new_grp == GRP_RSVD) |=> $stable(ctl.grp));
    p_cfg_only_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_cfg |=> ($stable(ctl.en) && $stable(ctl.rate) && $stable(ctl.grp)));
    p_mode_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |=> (ctl.en == $past(wr_word[EN_LSB +: EN_BITS])));
endmodule

// File: rtl/sercfg_regif.sv
// Module: top level of the serial control register port. Chains the
// synchroniser, the shifter and the register file. Assumes clk runs at
// least four times faster than ser_clk_i.
module sercfg_regif
    import sercfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk_i,
    input  logic                 ser_dat_i,
    input  logic                 ser_stb_i,
    output logic [EN_BITS-1:0]   out_en_o,
    output logic [CODE_BITS-1:0] rate_sel_o,
    output logic [CODE_BITS-1:0] grp_sel_o,
    output logic                 alt_cfg_o,
    output logic                 pwrdn_o
);
    logic [2:0]           sync_v;
    logic                 word_vld;
    logic [WORD_BITS-1:0] word;
    ctl_t                 ctl;

    sercfg_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_stb_i, ser_dat_i, ser_clk_i}),
        .sync_o  (sync_v)
    );

    sercfg_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_s   (sync_v[0]),
        .bdat_s   (sync_v[1]),
        .stb_s    (sync_v[2]),
        .word_vld (word_vld),
        .word     (word)
    );

    sercfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_vld  (word_vld),
        .wr_word (word),
        .ctl     (ctl),
        .pwrdn   (pwrdn_o)
    );

    assign out_en_o   = ctl.en;
    assign rate_sel_o = ctl.rate;
    assign grp_sel_o  = ctl.grp;
    assign alt_cfg_o  = ctl.alt;

    p_pwrdn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_o |-> (out_en_o == '0));
endmodule

// File: tb/sercfg_regif_bench.sv
module sercfg_regif_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0;
    logic [5:0] out_en;
    logic [1:0] rate_sel, grp_sel;
    logic       alt_cfg, pwrdn;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    sercfg_regif u_sercfg_regif (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_stb_i(ser_stb),
        .out_en_o(out_en), .rate_sel_o(rate_sel), .grp_sel_o(grp_sel),
        .alt_cfg_o(alt_cfg), .pwrdn_o(pwrdn)
    );

    // Each entry: {word[27:12], en[11:6], rate[5:4], grp[3:2], alt[1], pd[0]}
    localparam logic [27:0] VEC [8] = '{
        {16'h72A6, 6'b101010, 2'b01, 2'b10, 1'b0, 1'b0},
        {16'h7159, 6'b010101, 2'b10, 2'b01, 1'b0, 1'b0},
        {16'h73FF, 6'b111111, 2'b10, 2'b01, 1'b0, 1'b0},
        {16'h6FFF, 6'b111111, 2'b10, 2'b01, 1'b1, 1'b0},
        {16'hF000, 6'b111111, 2'b10, 2'b01, 1'b1, 1'b0},
        {16'h7000, 6'b000000, 2'b00, 2'b00, 1'b1, 1'b1},
        {16'h6C00, 6'b000000, 2'b00, 2'b00, 1'b0, 1'b1},
        {16'h7012, 6'b000001, 2'b00, 2'b10, 1'b0, 1'b0}
    };

    function automatic string vec_req(int idx);
        case (idx)
            0, 1:    return "R3";
            2:       return "R5 R6";
            3:       return "R4";
            4:       return "R7";
            5, 6:    return "R8";
            default: return "R8 R3";
        endcase
    endfunction

    task automatic check(string req, logic [11:0] exp);
        logic [11:0] act;
        act = {out_en, rate_sel, grp_sel, alt_cfg, pwrdn};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic send_bits(logic [31:0] val, int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_clk = 1'b0; ser_dat = val[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
        end
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk); ser_stb = 1'b1;
        repeat (6) @(negedge clk);
        ser_stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", {6'b111111, 2'b00, 2'b00, 1'b0, 1'b0});

        for (int k = 0; k < 8; k++) begin
            send_bits({16'h0, VEC[k][27:12]}, 16);
            strobe();
            check(vec_req(k), VEC[k][11:0]);
        end

        // R2: a word one bit short is dropped.
        send_bits({16'h0, 16'h73F5}, 15);
        strobe();
        check("R2 short word", {6'b000001, 2'b00, 2'b10, 1'b0, 1'b0});

        // R9: four leading junk bits, then a full word.
        send_bits({12'h0, 4'hA, 16'h7159}, 20);
        strobe();
        check("R9 last 16 bits", {6'b010101, 2'b10, 2'b01, 1'b0, 1'b0});

        // R10: exact latency from the strobe pin to the outputs.
        send_bits({16'h0, 16'h72A6}, 16);
        @(negedge clk); ser_stb = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 old after third edge", {6'b010101, 2'b10, 2'b01, 1'b0, 1'b0});
        @(posedge clk);
        @(negedge clk);
        check("R10 new after fourth edge", {6'b101010, 2'b01, 2'b10, 1'b0, 1'b0});
        repeat (4) @(negedge clk);
        ser_stb = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset in mid-operation restores the defaults.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 re-reset", {6'b111111, 2'b00, 2'b00, 1'b0, 1'b0});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule